// File: doc/BRIEF.md
# ISA Register Write Legalizer

This block holds the 32-bit machine ISA register of one hart. Software writes arrive on a strobe with a data word. The block never stores a write as given. It either drops the write or reduces it to a legal encoding first. The legal encoding depends on which extensions the hart implements, on the dependencies between extension letters, and on the alignment of the next instruction.

Extension bit n stands for the letter 'A'+n: A=0, C=2, D=3, E=4, F=5, I=8, M=12, S=18, U=20. Bits 31:30 hold the XLEN field, which software cannot change. Bits 29:26 always read zero.

Whenever the stored value changes, the block pulses a flush output for one cycle. Downstream logic uses this pulse to discard state that was decoded under the old extension set.

Top module: `isa_reg_legalizer`

## Requirements
- R1: While reset is asserted and after it is released, the register reads XLEN=01 in bits 31:30. Its extension bits are I, M, A, F, D, C, S and U, ANDed with the supported-extension mask. All other bits read zero.
- R2: When the writable strap is low, a write leaves the register unchanged.
- R3: A write whose data has neither bit 8 (I) nor bit 4 (E) set leaves the register unchanged.
- R4: A write whose data has bit 4 (E) set leaves the register unchanged, whatever its other bits are.
- R5: An accepted write stores the data ANDed with the supported-extension mask and with the letter set {A, C, D, E, F, I, M, S, U}. Bits 29:26 and letters outside that set store zero.
- R6: If bit 3 (D) survives masking but bit 5 (F) does not, D is stored as zero.
- R7: If bit 2 (C) survives masking and next-instruction address bits 1:0 are not zero, C is stored as zero.
- R8: Bits 31:30 keep their previous value on every write.
- R9: The flush output is high for exactly the one cycle after the edge at which the stored value changes. It stays low when an accepted write leaves the value equal.
- R10: With the write strobe low, the register and the flush output do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| ext_mask_i | input | 26 | Static mask of the extensions the hart supports |
| writable_i | input | 1 | Strap that lets software write the register |
| next_pc_i | input | 32 | Address of the next instruction |
| isa_o | output | 32 | Current register value |
| flush_o | output | 1 | One-cycle pulse when the stored value changed |

## Verification
The bench writes a sequence of words that each hit one rule. A word with no base letter and a word with the embedded base are both dropped. A word with D but no F tells the dependency fix apart from plain masking. The same C-carrying word is written with an aligned and then a misaligned next address, which isolates the alignment rule. A word with ones in the XLEN field, in the reserved bits and on an unlisted letter shows which bits are kept, which are forced to zero and which are masked. Repeated identical writes separate a real value change, which raises flush, from an accepted write that changes nothing, which leaves flush low. A narrowed supported mask checks both the reset value and the masking of writes.

// File: rtl/isa_legal_pkg.sv
package isa_legal_pkg;
  localparam int unsigned EXT_W = 26;

  localparam int unsigned BIT_A = 0;
  localparam int unsigned BIT_C = 2;
  localparam int unsigned BIT_D = 3;
  localparam int unsigned BIT_E = 4;
  localparam int unsigned BIT_F = 5;
  localparam int unsigned BIT_I = 8;
  localparam int unsigned BIT_M = 12;
  localparam int unsigned BIT_S = 18;
  localparam int unsigned BIT_U = 20;

  localparam logic [EXT_W-1:0] LEGAL_LETTERS =
    EXT_W'((1 << BIT_A) | (1 << BIT_C) | (1 << BIT_D) | (1 << BIT_E) | (1 << BIT_F) |
           (1 << BIT_I) | (1 << BIT_M) | (1 << BIT_S) | (1 << BIT_U));

  localparam logic [EXT_W-1:0] RESET_LETTERS =
    EXT_W'((1 << BIT_I) | (1 << BIT_M) | (1 << BIT_A) | (1 << BIT_F) |
           (1 << BIT_D) | (1 << BIT_C) | (1 << BIT_S) | (1 << BIT_U));

  localparam logic [1:0] XLEN_RESET = 2'b01;
endpackage

// File: rtl/isa_write_gate.sv
module isa_write_gate
  import isa_legal_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr_en_i,
  input  logic              writable_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              accept_o
);
  logic has_base;
  logic has_embedded;

  assign has_base     = wr_data_i[BIT_I] | wr_data_i[BIT_E];
  assign has_embedded = wr_data_i[BIT_E];
  // embedded base unsupported: the whole write is dropped
  assign accept_o     = wr_en_i & writable_i & has_base & ~has_embedded;
endmodule

// File: rtl/isa_ext_filter.sv
module isa_ext_filter
  import isa_legal_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic [EXT_W-1:0]      raw_i,
  input  logic [EXT_W-1:0]      mask_i,
  input  logic [ALIGN_BITS-1:0] pc_lo_i,
  output logic [EXT_W-1:0]      ext_o
);
  logic [EXT_W-1:0] masked;
  logic             pc_misaligned;

  for (genvar n = 0; n < EXT_W; n++) begin : g_mask
    assign masked[n] = raw_i[n] & mask_i[n] & LEGAL_LETTERS[n];
  end

  assign pc_misaligned = |pc_lo_i;

  always_comb begin
    ext_o = masked;
    if (masked[BIT_D] && !masked[BIT_F]) ext_o[BIT_D] = 1'b0;
    if (masked[BIT_C] && pc_misaligned)  ext_o[BIT_C] = 1'b0;
  end
endmodule

// File: rtl/isa_reg_legalizer.sv
module isa_reg_legalizer
  import isa_legal_pkg::*;
#(
  parameter int unsigned XLEN_W     = 32,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [XLEN_W-1:0] wr_data_i,
  input  logic [EXT_W-1:0]  ext_mask_i,
  input  logic              writable_i,
  input  logic [PC_W-1:0]   next_pc_i,
  output logic [XLEN_W-1:0] isa_o,
  output logic              flush_o
);
  localparam int unsigned PAD_W = XLEN_W - 2 - EXT_W;

  logic              accept;
  logic [EXT_W-1:0]  ext_legal;
  logic [XLEN_W-1:0] next_val;
  logic [XLEN_W-1:0] isa_q;
  logic              flush_q;
  logic              unused_pc;
  logic [XLEN_W-1:0] reset_val;

  assign unused_pc = ^next_pc_i[PC_W-1:ALIGN_BITS];
  assign reset_val = {XLEN_RESET, {PAD_W{1'b0}}, RESET_LETTERS & ext_mask_i};

  isa_write_gate #(.DATA_W(XLEN_W)) u_gate (
    .wr_en_i    (wr_en_i),
    .writable_i (writable_i),
    .wr_data_i  (wr_data_i),
    .accept_o   (accept)
  );

  isa_ext_filter #(.ALIGN_BITS(ALIGN_BITS)) u_filter (
    .raw_i   (wr_data_i[EXT_W-1:0]),
    .mask_i  (ext_mask_i),
    .pc_lo_i (next_pc_i[ALIGN_BITS-1:0]),
    .ext_o   (ext_legal)
  );

  // XLEN field carried from the stored value
  assign next_val = {isa_q[XLEN_W-1:XLEN_W-2], {PAD_W{1'b0}}, ext_legal};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isa_q   <= reset_val;
      flush_q <= 1'b0;
    end else begin
      flush_q <= accept && (next_val != isa_q);
      if (accept) isa_q <= next_val;
    end
  end

  assign isa_o   = isa_q;
  assign flush_o = flush_q;

  p_xlen_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(isa_q[XLEN_W-1:XLEN_W-2]));
  p_strap_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !writable_i |=> $stable(isa_q));
  p_no_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(isa_q) && !flush_q));
  p_embedded_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i[BIT_E] |=> $stable(isa_q));
  p_no_base_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_data_i[BIT_I] || wr_data_i[BIT_E]) |=> $stable(isa_q));
  p_flush_on_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> (isa_q != $past(isa_q)));
  p_change_has_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isa_q != $past(isa_q)) |-> flush_q);
  p_d_needs_f_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> !(isa_q[BIT_D] && !isa_q[BIT_F]));
  p_pad_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isa_q[XLEN_W-3:EXT_W] == '0);
endmodule

// File: tb/tb_isa_reg_legalizer.sv
module tb_isa_reg_legalizer;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_VEC = 11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [25:0] ext_mask_i = 26'h3FF_FFFF;
  logic        writable_i = 1'b1;
  logic [31:0] next_pc_i = 32'h0000_1000;
  logic [31:0] isa_o;
  logic        flush_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  isa_reg_legalizer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ext_mask_i(ext_mask_i), .writable_i(writable_i), .next_pc_i(next_pc_i),
    .isa_o(isa_o), .flush_o(flush_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // {strap, data, pc[1:0], expected value, expected flush}
  localparam logic [67:0] VEC [N_VEC] = '{
    {1'b1, 32'h0000_0100, 2'd0, 32'h4000_0100, 1'b1},  // R5 I only
    {1'b1, 32'h0000_0100, 2'd0, 32'h4000_0100, 1'b0},  // R9 same value
    {1'b1, 32'hFFFF_FFFF, 2'd0, 32'h4000_0100, 1'b0},  // R4 E set
    {1'b1, 32'h0000_112D, 2'd0, 32'h4000_112D, 1'b1},  // R5 IMAFDC
    {1'b1, 32'h0000_110D, 2'd0, 32'h4000_1105, 1'b1},  // R6 D w/o F
    {1'b1, 32'h0000_1105, 2'd2, 32'h4000_1101, 1'b1},  // R7 misaligned
    {1'b1, 32'h0000_1105, 2'd0, 32'h4000_1105, 1'b1},  // R7 aligned
    {1'b1, 32'h0000_1001, 2'd0, 32'h4000_1105, 1'b0},  // R3 no base
    {1'b0, 32'h0000_0100, 2'd0, 32'h4000_1105, 1'b0},  // R2 strap off
    {1'b1, 32'hBC00_0140, 2'd0, 32'h4000_0100, 1'b1},  // R8 R5 xlen/pad/G
    {1'b1, 32'h0014_0120, 2'd0, 32'h4014_0120, 1'b1}   // R5 IFSU
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic strap, input logic [31:0] data, input logic [1:0] pc_lo);
    @(negedge clk_i);
    writable_i = strap;
    wr_data_i  = data;
    next_pc_i  = {30'h0000_0400, pc_lo};
    wr_en_i    = 1'b1;
    @(negedge clk_i);
    wr_en_i    = 1'b0;
    writable_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset hold", isa_o, 32'h4014_112D);
    check("R1 reset flush", {31'd0, flush_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", isa_o, 32'h4014_112D);

    for (int i = 0; i < N_VEC; i++) begin
      do_write(VEC[i][67], VEC[i][66:35], VEC[i][34:33]);
      check($sformatf("vec%0d value", i), isa_o, VEC[i][32:1]);
      check($sformatf("vec%0d R9 flush", i), {31'd0, flush_o}, {31'd0, VEC[i][0]});
    end

    // R9: pulse lasts one cycle
    do_write(1'b1, 32'h0000_0100, 2'd0);
    check("R9 flush on change", {31'd0, flush_o}, 32'd1);
    @(negedge clk_i);
    check("R9 flush one cycle", {31'd0, flush_o}, 32'd0);

    // R10: data on bus without strobe
    @(negedge clk_i);
    wr_data_i = 32'h0000_112D;
    writable_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R10 no strobe value", isa_o, 32'h4000_0100);
    check("R10 no strobe flush", {31'd0, flush_o}, 32'd0);

    // R1 R5: narrowed mask I|M|C
    rst_ni = 1'b0;
    ext_mask_i = 26'h000_1104;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset masked", isa_o, 32'h4000_1104);
    do_write(1'b1, 32'h0000_112D, 2'd0);
    check("R5 masked write", isa_o, 32'h4000_1104);
    check("R9 masked no flush", {31'd0, flush_o}, 32'd0);

    // R6: F unsupported, D supported
    ext_mask_i = 26'h000_0108;
    do_write(1'b1, 32'h0000_0128, 2'd0);
    check("R6 F masked clears D", isa_o, 32'h4000_0100);
    check("R6 flush", {31'd0, flush_o}, 32'd1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule